// File: doc/BRIEF.md
# Serial LED Sink Driver Core with Fault Capture

This block is the digital heart of an eight-channel LED sink driver. A serial bit stream enters on a data pin and moves through a shift register on each rising edge of a serial clock. The register's top bit leaves on a daisy-chain output, so several drivers can share one serial bus. A level-sensitive latch enable copies the shift register into an output control register. An active-low output enable gates the channel outputs. All serial pins are sampled by a faster system clock, which also runs the timers.

The output-enable pin has a second role. A short pattern of latch-enable and output-enable levels, seen across four serial clock edges, puts the block into a fault-detect mode. In that mode, a long enough low period on output enable (both in serial clock edges and in microseconds) loads the shift register with per-channel fault flags from external detectors. Software then clocks the flags out on the daisy-chain pin. Only one capture is allowed per entry into fault-detect mode. A second pattern returns the block to normal operation.

Top module: `ledsink_core`

## Requirements
- R1: After reset the shift register and the output control register hold zero, the daisy-chain output is 0 and the block is in normal mode, so every LED output stays 0 even with output enable low.
- R2: In normal operation each rising serial clock edge shifts the data input into bit 0, with the rest moving toward bit 7, so a byte sent MSB first ends with its first bit in bit 7. The daisy-chain output takes bit 7 on each falling serial clock edge and holds between falling edges.
- R3: While latch enable is high, the output control register follows the shift register.
- R4: LED output i is 1 only when output control bit i is 1 and output enable is low. With output enable high, all LED outputs are 0.
- R5: Four consecutive rising serial clock edges that sample (output-enable, latch-enable) as (1,0), (0,0), (1,0), (1,1), oldest first, move the block from normal mode into fault-detect mode. The sequence (1,0), (0,0), (1,0), (0,0) returns it to normal mode from either fault-detect state.
- R6: In fault-detect mode, once output enable has been low for at least MIN_LOW_EDGES rising serial clock edges (default 3) and at least MIN_LOW_US microseconds (default 2), the shift register is loaded from the fault inputs, with bit i equal to fault input i (1 means a faulty channel), and the data input is ignored.
- R7: A low period on output enable that is too short in edges or in time loads no fault data; the edges in it shift serial data in the normal way.
- R8: When output enable returns high after a capture, the daisy-chain output already shows fault bit 7 before any serial clock edge. The following clock pulses bring out bits 6 down to 0.
- R9: Outside fault-detect mode, a long low period on output enable captures nothing and acts as a normal output enable.
- R10: After a capture, no further capture takes place until an exit sequence and then a new enter sequence have been seen.
- R11: A capture clears the output control register, so the LED outputs go to 0 during and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for sampling and timing |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| le_i | input | 1 | Latch enable, active high |
| oe_ni | input | 1 | Output enable, active low; also starts a fault capture |
| fault_i | input | NUM_CH | Per-channel fault flags, 1 = fault |
| sdo_o | output | 1 | Serial data out for daisy-chaining |
| led_o | output | NUM_CH | Channel sink enables |

## Verification
The hardest states to reach are the near-misses around a capture. One is a low period in fault-detect mode with enough time but too few edges. Another has enough edges but too little time. A third is a long low period after a capture has already been spent. The bench reaches each of these by first loading a known byte, then holding output enable low for a chosen number of serial pulses and a chosen idle time. It then reads the byte back and checks whether it shifted normally or was replaced by the fault pattern. The spent state is reached only by running the full sequence: enter, load all ones, latch, capture, read out. The bench then shows that a new exit and enter restores the capture.

// File: rtl/ledsink_pkg.sv
package ledsink_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_ARMED  = 2'd1,
      MODE_SPENT  = 2'd2
   } ledsink_mode_e;

   localparam int unsigned CMD_LEN = 4;

   // history bit 3 is the oldest sampled edge, bit 0 the newest
   localparam logic [CMD_LEN-1:0] ENTER_OE_PAT = 4'b1011;
   localparam logic [CMD_LEN-1:0] ENTER_LE_PAT = 4'b0001;
   localparam logic [CMD_LEN-1:0] EXIT_OE_PAT  = 4'b1010;
   localparam logic [CMD_LEN-1:0] EXIT_LE_PAT  = 4'b0000;

endpackage

// File: rtl/ledsink_sync.sv
module ledsink_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("ledsink_sync: WIDTH must be at least 1");
   end
   if (STAGES > 8) begin : g_bad_stages
      $error("ledsink_sync: STAGES above 8 is not supported");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
         end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
         end
      end

      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/ledsink_cmd.sv
module ledsink_cmd
   import ledsink_pkg::*;
(
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          sclk_rise_i,
   input  logic          oe_n_i,
   input  logic          le_i,
   input  logic          cap_done_i,
   output ledsink_mode_e mode_o
);

   logic [CMD_LEN-1:0] oe_hist_q, le_hist_q;
   logic [CMD_LEN-1:0] oe_hist_d, le_hist_d;
   logic               hit_enter, hit_exit;
   ledsink_mode_e      mode_q, mode_d;

   assign oe_hist_d = {oe_hist_q[CMD_LEN-2:0], oe_n_i};
   assign le_hist_d = {le_hist_q[CMD_LEN-2:0], le_i};
   assign hit_enter = sclk_rise_i && (oe_hist_d == ENTER_OE_PAT) && (le_hist_d == ENTER_LE_PAT);
   assign hit_exit  = sclk_rise_i && (oe_hist_d == EXIT_OE_PAT)  && (le_hist_d == EXIT_LE_PAT);

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_NORMAL: if (hit_enter)  mode_d = MODE_ARMED;
         MODE_ARMED: begin
            if (hit_exit)             mode_d = MODE_NORMAL;
            else if (cap_done_i)      mode_d = MODE_SPENT;
         end
         MODE_SPENT:  if (hit_exit)   mode_d = MODE_NORMAL;
         default:                     mode_d = MODE_NORMAL;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         oe_hist_q <= '1;
         le_hist_q <= '0;
         mode_q    <= MODE_NORMAL;
      end else begin
         if (sclk_rise_i) begin
            oe_hist_q <= oe_hist_d;
            le_hist_q <= le_hist_d;
         end
         mode_q <= mode_d;
      end
   end

   assign mode_o = mode_q;

   // R5: fault-detect mode is entered only from normal mode
   p_enter_from_normal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_ARMED && $past(mode_q) != MODE_ARMED) |-> $past(mode_q) == MODE_NORMAL);

   // R10: a spent capture never re-arms directly
   p_spent_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_SPENT) |=> (mode_q != MODE_ARMED));

endmodule

// File: rtl/ledsink_lowtimer.sv
module ledsink_lowtimer #(
   parameter int unsigned CLK_PER_US = 125,
   parameter int unsigned MIN_US     = 2,
   parameter int unsigned MIN_EDGES  = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic oe_low_i,
   input  logic sclk_rise_i,
   output logic qualified_o
);

   localparam int unsigned DIV_W  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
   localparam int unsigned US_W   = $clog2(MIN_US + 1);
   localparam int unsigned EDGE_W = $clog2(MIN_EDGES + 1);
   localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(CLK_PER_US - 1);
   localparam logic [US_W-1:0]   US_SAT   = US_W'(MIN_US);
   localparam logic [EDGE_W-1:0] EDGE_SAT = EDGE_W'(MIN_EDGES);

   if (CLK_PER_US < 1) begin : g_bad_div
      $error("ledsink_lowtimer: CLK_PER_US must be at least 1");
   end
   if (MIN_US < 1 || MIN_EDGES < 1) begin : g_bad_min
      $error("ledsink_lowtimer: minimum edges and microseconds must be at least 1");
   end

   logic [DIV_W-1:0]  div_q;
   logic [US_W-1:0]   us_q;
   logic [EDGE_W-1:0] edge_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q  <= '0;
         us_q   <= '0;
         edge_q <= '0;
      end else if (!oe_low_i) begin
         div_q  <= '0;
         us_q   <= '0;
         edge_q <= '0;
      end else begin
         if (sclk_rise_i && edge_q != EDGE_SAT) edge_q <= edge_q + 1'b1;
         if (us_q != US_SAT) begin
            if (div_q == DIV_LAST) begin
               div_q <= '0;
               us_q  <= us_q + 1'b1;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   end

   assign qualified_o = oe_low_i && (edge_q == EDGE_SAT) && (us_q == US_SAT);

   // R7: a low period that has only just begun can never count as long enough
   p_fresh_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_low_i && !$past(oe_low_i)) |-> !qualified_o);

endmodule

// File: rtl/ledsink_core.sv
module ledsink_core
   import ledsink_pkg::*;
#(
   parameter int unsigned NUM_CH        = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned CLK_PER_US    = 125,
   parameter int unsigned MIN_LOW_US    = 2,
   parameter int unsigned MIN_LOW_EDGES = 3,
   parameter bit          LED_REG       = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sclk_i,
   input  logic              sdi_i,
   input  logic              le_i,
   input  logic              oe_ni,
   input  logic [NUM_CH-1:0] fault_i,
   output logic              sdo_o,
   output logic [NUM_CH-1:0] led_o
);

   localparam int unsigned SYN_W = NUM_CH + 4;
   localparam logic [SYN_W-1:0] SYN_RST = {3'b000, 1'b1, {NUM_CH{1'b0}}};

   if (NUM_CH < 2) begin : g_bad_ch
      $error("ledsink_core: NUM_CH must be at least 2");
   end

   logic [SYN_W-1:0]  syn_q;
   logic              sclk_s, sdi_s, le_s, oe_n_s;
   logic [NUM_CH-1:0] fault_s;

   ledsink_sync #(
      .WIDTH   (SYN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYN_RST)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({sclk_i, sdi_i, le_i, oe_ni, fault_i}),
      .q_o    (syn_q)
   );

   assign {sclk_s, sdi_s, le_s, oe_n_s, fault_s} = syn_q;

   logic sclk_prev_q;
   logic sclk_rise, sclk_fall;

   assign sclk_rise = sclk_s && !sclk_prev_q;
   assign sclk_fall = !sclk_s && sclk_prev_q;

   logic          qualified;
   logic          cap_active, cap_held_q, cap_done;
   ledsink_mode_e mode;

   ledsink_lowtimer #(
      .CLK_PER_US (CLK_PER_US),
      .MIN_US     (MIN_LOW_US),
      .MIN_EDGES  (MIN_LOW_EDGES)
   ) u_lowtimer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .oe_low_i    (!oe_n_s),
      .sclk_rise_i (sclk_rise),
      .qualified_o (qualified)
   );

   ledsink_cmd u_cmd (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sclk_rise_i (sclk_rise),
      .oe_n_i      (oe_n_s),
      .le_i        (le_s),
      .cap_done_i  (cap_done),
      .mode_o      (mode)
   );

   assign cap_active = (mode == MODE_ARMED) && qualified;
   assign cap_done   = cap_held_q && oe_n_s;

   logic [NUM_CH-1:0] shift_q, out_q;
   logic              sdo_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_prev_q <= 1'b0;
         cap_held_q  <= 1'b0;
         shift_q     <= '0;
         out_q       <= '0;
         sdo_q       <= 1'b0;
      end else begin
         sclk_prev_q <= sclk_s;

         if (cap_active)  cap_held_q <= 1'b1;
         else if (oe_n_s) cap_held_q <= 1'b0;

         if (cap_active)     shift_q <= fault_s;
         else if (sclk_rise) shift_q <= {shift_q[NUM_CH-2:0], sdi_s};

         if (cap_active) out_q <= '0;
         else if (le_s)  out_q <= shift_q;

         if (cap_active)     sdo_q <= fault_s[NUM_CH-1];
         else if (sclk_fall) sdo_q <= shift_q[NUM_CH-1];
      end
   end

   assign sdo_o = sdo_q;

   if (LED_REG) begin : g_led_reg
      logic [NUM_CH-1:0] led_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) led_q <= '0;
         else         led_q <= out_q & {NUM_CH{!oe_n_s}};
      end
      assign led_o = led_q;
   end else begin : g_led_comb
      assign led_o = out_q & {NUM_CH{!oe_n_s}};
   end

   // R6: a capture cycle leaves the sampled fault flags in the shift register
   p_fault_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_active |=> (shift_q == $past(fault_s)));

   // R11: a capture wipes the output control register
   p_out_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_active |=> (out_q == '0));

   // R2: the serial output moves only on a falling edge or a capture
   p_sdo_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sclk_fall && !cap_active) |=> $stable(sdo_q));

endmodule

// File: tb/ledsink_core_bench.sv
module ledsink_core_bench;

   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic le = 1'b0;
   logic oe_n = 1'b1;
   logic [N-1:0] fault = '0;
   logic sdo;
   logic [N-1:0] led;

   always #4 clk = ~clk;

   ledsink_core u_ledsink_core (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .sclk_i  (sclk),
      .sdi_i   (sdi),
      .le_i    (le),
      .oe_ni   (oe_n),
      .fault_i (fault),
      .sdo_o   (sdo),
      .led_o   (led)
   );

   int checks = 0;
   int errors = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] act_q[$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic d, input logic o, input logic l);
      @(negedge clk);
      sdi = d; oe_n = o; le = l;
      idle(8);
      sclk = 1'b1;
      idle(8);
      sclk = 1'b0;
      idle(8);
   endtask

   task automatic load_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) pulse(v[i], 1'b1, 1'b0);
   endtask

   task automatic latch();
      @(negedge clk);
      le = 1'b1;
      idle(6);
      le = 1'b0;
      idle(6);
   endtask

   // driver side of the scoreboard: expected byte is queued, the read result is queued
   task automatic expect_read(input logic [7:0] v, input string tag);
      logic [7:0] b;
      exp_q.push_back(v);
      tag_q.push_back(tag);
      for (int i = 7; i >= 0; i--) begin
         b[i] = sdo;
         pulse(1'b0, 1'b1, 1'b0);
      end
      act_q.push_back(b);
   endtask

   task automatic low_window(input int n, input logic [3:0] bits, input int hold);
      @(negedge clk);
      oe_n = 1'b0;
      for (int i = n - 1; i >= 0; i--) pulse(bits[i], 1'b0, 1'b0);
      idle(hold);
      oe_n = 1'b1;
      idle(8);
   endtask

   task automatic cmd_enter();
      pulse(1'b0, 1'b1, 1'b0);
      pulse(1'b0, 1'b0, 1'b0);
      pulse(1'b0, 1'b1, 1'b0);
      pulse(1'b0, 1'b1, 1'b1);
   endtask

   task automatic cmd_exit();
      pulse(1'b0, 1'b1, 1'b0);
      pulse(1'b0, 1'b0, 1'b0);
      pulse(1'b0, 1'b1, 1'b0);
      pulse(1'b0, 1'b0, 1'b0);
   endtask

   task automatic capture(input logic [7:0] f);
      fault = f;
      @(negedge clk);
      oe_n = 1'b0;
      idle(6);
      check("R4 all channels lit before capture", led, 8'hFF);
      for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0, 1'b0);
      idle(300);
      check("R11 outputs cleared by capture", led, 8'h00);
      oe_n = 1'b1;
      idle(8);
      check("R8 fault MSB on sdo before any clock", sdo, f[7]);
   endtask

   // monitor side of the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, a, e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(4);
      oe_n = 1'b0;
      idle(6);
      check("R1 leds dark after reset", led, 8'h00);
      check("R1 sdo low after reset", sdo, 1'b0);
      oe_n = 1'b1;
      idle(6);

      // normal load, latch, gating, daisy-chain read
      load_byte(8'hC6);
      latch();
      check("R4 leds dark with oe high", led, 8'h00);
      oe_n = 1'b0;
      idle(6);
      check("R3 latched pattern on leds", led, 8'hC6);
      oe_n = 1'b1;
      idle(6);
      check("R4 leds dark again with oe high", led, 8'h00);
      expect_read(8'hC6, "R2 msb-first shift out");

      // long low in normal mode: plain shifting, no capture
      fault = 8'hFF;
      low_window(4, 4'b1011, 300);
      expect_read(8'h0B, "R9 no capture in normal mode");

      // fault-detect mode, near misses
      cmd_enter();
      load_byte(8'hA5);
      fault = 8'h3C;
      low_window(2, 4'b0010, 300);
      expect_read(8'h96, "R7 too few edges");
      load_byte(8'h3C);
      fault = 8'h55;
      low_window(4, 4'b1111, 0);
      expect_read(8'hCF, "R7 too short in time");

      // real capture
      load_byte(8'hFF);
      latch();
      capture(8'hA3);
      expect_read(8'hA3, "R6 fault flags shifted out");

      // spent: second long low is plain
      fault = 8'h5A;
      low_window(4, 4'b1111, 300);
      expect_read(8'h0F, "R10 no second capture");

      // exit then enter re-arms
      cmd_exit();
      cmd_enter();
      load_byte(8'hFF);
      latch();
      capture(8'h81);
      expect_read(8'h81, "R10 capture after re-entry");

      // exit returns to normal
      cmd_exit();
      fault = 8'hFF;
      low_window(4, 4'b1111, 300);
      expect_read(8'h0F, "R5 exit restores normal mode");

      idle(20);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule